// File: doc/BRIEF.md
# Associative Memory Pattern Matcher

This block is a content-addressable bank of track patterns for fast pattern recognition. Every pattern holds one coarse-bin word for each detector layer (five silicon layers and one drift-chamber layer by default). In load mode, software-free control logic writes and reads these words over a shared data bus. The pattern is chosen by an address and the layer by a plane-select code.

In run mode, hits stream in on the same data bus, each tagged with its layer by the plane-select code. Every pattern has its own comparator per layer, so the whole bank checks a hit in the same cycle. A pattern that sees its word on the tagged layer sets a sticky flag for that layer. A pattern counts as matched once the number of set flags reaches a programmable threshold, for example four of six. Because matching runs while hits are still arriving, the result is ready as soon as the last hit has arrived.

A drain operation then reports the matched pattern addresses one per operation, lowest number first, through a priority encoder. An event-clear operation wipes all flags for the next event.

Top module: `am_matcher`

## Requirements
- R1: A write (opcode 1) stores `data_i` into pattern `addr_i`, layer `plane_i`. A read (opcode 2) returns that word on `rdata_o` with `rdata_valid_o` high on the cycle after the read. Planes 6 and 7 are not layers: a write to them is dropped and a read of them returns 0.
- R2: A hit (opcode 3) with plane `p` (0 to 5) sets the layer-`p` flag in every pattern whose layer-`p` word equals `data_i`, all in the same cycle. A hit with plane 6 or 7 sets no flag.
- R3: Flags stay set until an event clear. A repeated hit on an already flagged layer does not raise that pattern's flag count. A hit that equals no stored word changes nothing.
- R4: A pattern is matched when its count of set layer flags is greater than or equal to `thresh_i`. The threshold is read live, so raising or lowering it between drains changes which patterns are pending.
- R5: A drain (opcode 4) with at least one matched, not yet reported pattern drives the lowest such pattern number on `match_addr_o`, with `match_valid_o` high on the next cycle. That pattern is then marked reported and is not reported again in the same event.
- R6: A drain with nothing pending raises `done_o` on the next cycle with `match_valid_o` low. `match_valid_o` and `done_o` are never high together.
- R7: An event clear (opcode 5) resets every layer flag and every reported mark in one cycle, so a drain right after it gives `done_o`.
- R8: After reset, and on the cycle after any opcode other than drain, `match_valid_o` and `done_o` are low. `rdata_valid_o` is high only on the cycle after a read. Opcodes 0, 6 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation: 0 idle, 1 write, 2 read, 3 hit, 4 drain, 5 clear |
| addr_i | input | 7 | Pattern number for write and read |
| plane_i | input | 3 | Layer select for write, read and hit |
| data_i | input | 12 | Word to write, or hit bin value |
| thresh_i | input | 3 | Minimum number of flagged layers for a match |
| rdata_o | output | 12 | Word returned by a read |
| rdata_valid_o | output | 1 | `rdata_o` valid |
| match_valid_o | output | 1 | `match_addr_o` holds a matched pattern |
| match_addr_o | output | 7 | Matched pattern number |
| done_o | output | 1 | Drain found no pending pattern |

## Verification
Three patterns share identical words, so one hit set must drain as an ordered group. A design that encoded the highest pattern first, or reported one pattern twice, would break the scoreboard's order. The threshold is lowered after a drain without a clear. Only the newly matched pattern may appear, which catches lost or stale reported marks. Repeated hits on one layer, hits with no matching word and hits on planes 6 and 7 are each followed by a drain that must report done. A design that counted hits instead of layers, or that decoded every plane, would report a match there. A clear followed by a drain must report done at once.

// File: rtl/am_pkg.sv
package am_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_WRITE = 3'd1,
    OP_READ  = 3'd2,
    OP_HIT   = 3'd3,
    OP_DRAIN = 3'd4,
    OP_CLEAR = 3'd5
  } am_op_e;
endpackage

// File: rtl/am_pattern.sv
module am_pattern #(
  parameter int NUM_LAYER = 6,
  parameter int WORD_W    = 12,
  parameter int PLANE_W   = 3,
  parameter int CNT_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_i,
  input  am_pkg::am_op_e       op_i,
  input  logic [PLANE_W-1:0]   plane_i,
  input  logic [WORD_W-1:0]    data_i,
  input  logic [CNT_W-1:0]     thresh_i,
  input  logic                 take_i,
  output logic [WORD_W-1:0]    word_o,
  output logic                 pending_o
);
  import am_pkg::*;

  logic [NUM_LAYER-1:0][WORD_W-1:0] word_q, word_d;
  logic [NUM_LAYER-1:0]             flag_q, flag_d;
  logic [NUM_LAYER-1:0]             layer_hit;
  logic [NUM_LAYER-1:0]             layer_sel;
  logic                             taken_q, taken_d;
  logic                             word_en, state_en;
  logic [CNT_W-1:0]                 flag_cnt;

  // one private comparator per layer word
  for (genvar l = 0; l < NUM_LAYER; l++) begin : g_layer
    assign layer_sel[l] = (plane_i == PLANE_W'(l));
    assign layer_hit[l] = layer_sel[l] && (word_q[l] == data_i);
  end

  always_comb begin
    word_d = word_q;
    for (int l = 0; l < NUM_LAYER; l++) begin
      if (layer_sel[l]) word_d[l] = data_i;
    end
  end

  always_comb begin
    word_o = '0;
    for (int l = 0; l < NUM_LAYER; l++) begin
      if (layer_sel[l]) word_o = word_q[l];
    end
  end

  always_comb begin
    flag_d  = flag_q;
    taken_d = taken_q;
    if (op_i == OP_CLEAR) begin
      flag_d  = '0;
      taken_d = 1'b0;
    end else begin
      if (op_i == OP_HIT) flag_d = flag_q | layer_hit;
      if (take_i)         taken_d = 1'b1;
    end
  end

  assign word_en  = (op_i == OP_WRITE) && sel_i;
  assign state_en = (op_i == OP_CLEAR) || (op_i == OP_HIT) || take_i;

  assign flag_cnt  = CNT_W'($countones(flag_q));
  assign pending_o = (flag_cnt >= thresh_i) && !taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      taken_q <= 1'b0;
    end else if (state_en) begin
      flag_q  <= flag_d;
      taken_q <= taken_d;
    end
  end
endmodule

// File: rtl/am_prio_enc.sv
module am_prio_enc #(
  parameter int NUM   = 128,
  parameter int IDX_W = $clog2(NUM)
) (
  input  logic [NUM-1:0]   req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/am_matcher.sv
module am_matcher #(
  parameter int NUM_PAT   = 128,
  parameter int NUM_LAYER = 6,
  parameter int WORD_W    = 12,
  parameter int ADDR_W    = $clog2(NUM_PAT),
  parameter int PLANE_W   = $clog2(NUM_LAYER),
  parameter int CNT_W     = $clog2(NUM_LAYER + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         op_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [PLANE_W-1:0] plane_i,
  input  logic [WORD_W-1:0]  data_i,
  input  logic [CNT_W-1:0]   thresh_i,
  output logic [WORD_W-1:0]  rdata_o,
  output logic               rdata_valid_o,
  output logic               match_valid_o,
  output logic [ADDR_W-1:0]  match_addr_o,
  output logic               done_o
);
  import am_pkg::*;

  am_op_e                          op;
  logic [NUM_PAT-1:0][WORD_W-1:0]  pat_word;
  logic [NUM_PAT-1:0]              pending;
  logic [NUM_PAT-1:0]              take;
  logic [ADDR_W-1:0]               first_idx;
  logic                            first_any;
  logic                            drain;

  logic [WORD_W-1:0] rdata_d;
  logic              rdata_valid_d, match_valid_d, done_d;
  logic [ADDR_W-1:0] match_addr_d;
  logic              rdata_en;

  assign op    = am_op_e'(op_i);
  assign drain = (op == OP_DRAIN);

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    assign take[p] = drain && first_any && (first_idx == ADDR_W'(p));
    am_pattern #(
      .NUM_LAYER (NUM_LAYER),
      .WORD_W    (WORD_W),
      .PLANE_W   (PLANE_W),
      .CNT_W     (CNT_W)
    ) u_pat (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (addr_i == ADDR_W'(p)),
      .op_i      (op),
      .plane_i   (plane_i),
      .data_i    (data_i),
      .thresh_i  (thresh_i),
      .take_i    (take[p]),
      .word_o    (pat_word[p]),
      .pending_o (pending[p])
    );
  end

  am_prio_enc #(
    .NUM   (NUM_PAT),
    .IDX_W (ADDR_W)
  ) u_enc (
    .req_i (pending),
    .idx_o (first_idx),
    .any_o (first_any)
  );

  always_comb begin
    rdata_valid_d = (op == OP_READ);
    rdata_en      = rdata_valid_d;
    rdata_d       = pat_word[addr_i];
    match_valid_d = drain && first_any;
    done_d        = drain && !first_any;
    match_addr_d  = match_valid_d ? first_idx : match_addr_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_valid_o <= 1'b0;
      match_valid_o <= 1'b0;
      match_addr_o  <= '0;
      done_o        <= 1'b0;
    end else begin
      rdata_valid_o <= rdata_valid_d;
      match_valid_o <= match_valid_d;
      match_addr_o  <= match_addr_d;
      done_o        <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
    end else if (rdata_en) begin
      rdata_o <= rdata_d;
    end
  end
endmodule

// File: rtl/am_matcher_chk.sv
module am_matcher_chk #(
  parameter int ADDR_W  = 7,
  parameter int PLANE_W = 3,
  parameter int WORD_W  = 12,
  parameter int CNT_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         op_i,
  input logic               rdata_valid_o,
  input logic               match_valid_o,
  input logic [ADDR_W-1:0]  match_addr_o,
  input logic               done_o
);
  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_valid_o && done_o));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != 3'd4) |=> (!match_valid_o && !done_o));

  assert_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd2) |=> rdata_valid_o);

  assert_noread_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != 3'd2) |=> !rdata_valid_o);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd5) ##1 (op_i == 3'd4) |=> (done_o && !match_valid_o));

  assert_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd4) |=> (match_valid_o || done_o));
endmodule

bind am_matcher am_matcher_chk #(
  .ADDR_W  (ADDR_W),
  .PLANE_W (PLANE_W),
  .WORD_W  (WORD_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_i          (op_i),
  .rdata_valid_o (rdata_valid_o),
  .match_valid_o (match_valid_o),
  .match_addr_o  (match_addr_o),
  .done_o        (done_o)
);

// File: tb/tb_am_matcher.sv
module tb_am_matcher;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_i;
  logic [6:0]  addr_i;
  logic [2:0]  plane_i;
  logic [11:0] data_i;
  logic [2:0]  thresh_i;
  logic [11:0] rdata_o;
  logic        rdata_valid_o, match_valid_o, done_o;
  logic [6:0]  match_addr_o;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  am_matcher dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .addr_i(addr_i),
    .plane_i(plane_i), .data_i(data_i), .thresh_i(thresh_i),
    .rdata_o(rdata_o), .rdata_valid_o(rdata_valid_o),
    .match_valid_o(match_valid_o), .match_addr_o(match_addr_o),
    .done_o(done_o)
  );

  task automatic fail(string req, int act, int exp);
    errors++;
    $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  task automatic do_op(input logic [2:0] op, input int addr, input int plane, input int data);
    @(negedge clk);
    op_i    = op;
    addr_i  = 7'(addr);
    plane_i = 3'(plane);
    data_i  = 12'(data);
    @(posedge clk);
    #1;
    op_i = 3'd0;
  endtask

  // scoreboard monitor: every reported address must be the next expected
  always @(negedge clk) begin
    if (rst_n && match_valid_o) begin
      checks++;
      if (exp_q.size() == 0) fail("R5 unexpected match", int'(match_addr_o), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        if (int'(match_addr_o) != e) fail("R5 match order", int'(match_addr_o), e);
      end
    end
  end

  task automatic drain_expect(input int addr);
    exp_q.push_back(addr);
    do_op(3'd4, 0, 0, 0);
  endtask

  task automatic drain_done(input string req);
    do_op(3'd4, 0, 0, 0);
    checks++;
    if (!(done_o && !match_valid_o)) fail(req, int'({done_o, match_valid_o}), 2);
  endtask

  task automatic read_check(input int addr, input int plane, input int exp, input string req);
    do_op(3'd2, addr, plane, 0);
    checks++;
    if (!rdata_valid_o || int'(rdata_o) != exp) fail(req, int'(rdata_o), exp);
  endtask

  function automatic int wordof(input int p, input int l);
    return p * 8 + l;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fail("watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_i = 0; addr_i = 0; plane_i = 0; data_i = 0; thresh_i = 3'd6;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (match_valid_o || done_o || rdata_valid_o) fail("R8 reset", 1, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // load mode, R1
    for (int p = 0; p < 128; p++)
      for (int l = 0; l < 6; l++)
        do_op(3'd1, p, l, wordof(p, l));
    for (int l = 0; l < 6; l++) begin
      do_op(3'd1, 40, l, wordof(3, l));
      do_op(3'd1, 90, l, wordof(3, l));
    end
    do_op(3'd1, 9, 7, 555);
    checks++;
    if (match_valid_o || done_o || rdata_valid_o) fail("R8 after write", 1, 0);
    read_check(77, 4, wordof(77, 4), "R1 readback");
    read_check(40, 2, wordof(3, 2), "R1 overwrite");
    read_check(127, 5, wordof(127, 5), "R1 top pattern");
    read_check(9, 7, 0, "R1 invalid plane");

    // event A, R2 R3 R4 R5 R6
    thresh_i = 3'd6;
    for (int l = 0; l < 6; l++) do_op(3'd3, 0, l, wordof(3, l));
    do_op(3'd3, 0, 0, wordof(3, 0));
    do_op(3'd3, 0, 0, 4000);
    for (int l = 0; l < 5; l++) do_op(3'd3, 0, l, wordof(100, l));
    checks++;
    if (match_valid_o || done_o) fail("R8 after hit", 1, 0);
    drain_expect(3);
    drain_expect(40);
    drain_expect(90);
    drain_done("R6 done after group");

    // R4 threshold lowered, reported marks kept
    thresh_i = 3'd5;
    drain_expect(100);
    drain_done("R6 done after threshold change");

    // R7 clear
    do_op(3'd5, 0, 0, 0);
    drain_done("R7 clear");

    // event B, R2 invalid plane, R4 threshold 4
    thresh_i = 3'd4;
    for (int l = 0; l < 3; l++) do_op(3'd3, 0, l, wordof(7, l));
    do_op(3'd3, 0, 6, wordof(7, 3));
    do_op(3'd3, 0, 7, wordof(7, 3));
    do_op(3'd3, 0, 1, wordof(127, 1));
    do_op(3'd3, 0, 2, wordof(127, 2));
    do_op(3'd3, 0, 3, wordof(127, 3));
    do_op(3'd3, 0, 5, wordof(127, 5));
    drain_expect(127);
    drain_done("R2 plane 6/7 ignored");
    do_op(3'd3, 0, 3, wordof(7, 3));
    drain_expect(7);
    drain_done("R5 no repeat");

    // event C, R3 repeated and unmatched hits
    do_op(3'd5, 0, 0, 0);
    thresh_i = 3'd2;
    do_op(3'd3, 0, 1, wordof(50, 1));
    do_op(3'd3, 0, 1, wordof(50, 1));
    drain_done("R3 repeated hit");
    do_op(3'd3, 0, 0, 4000);
    drain_done("R3 unmatched hit");
    do_op(3'd3, 0, 2, wordof(50, 2));
    drain_expect(50);
    drain_done("R6 final");

    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) fail("R5 missing matches", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule